// File: doc/BRIEF.md
# Strobe-qualified DAC code register

This block holds the 8-bit code that drives a digital-to-analog converter on a parallel processor bus. A write takes place when one of the two active-low bus strobes (chip select and write) returns high while the other is still low. Holding both strobes low never lets bus activity reach the code: the register changes only at the moment the write cycle ends. An active-low clear input empties the register at once, and the value stays zero until a later complete write cycle.

The strobes and the clear input reach the block as ordinary asynchronous pins. They are brought into the system clock domain by flop chains, and a small state machine follows the strobe pair. The machine has five states: `ST_CLEAR` (clear active or still synchronising), `ST_IDLE` (both strobes high), `ST_CS_ONLY` (select low, write high), `ST_WR_ONLY` (write low, select high) and `ST_BOTH_LOW`. In every state except `ST_CLEAR`, the next state is chosen from the synchronised strobe pair.

- `ST_CLEAR` moves to the state that matches the strobes once the synchronised clear reads high.
- Every other state moves to the state that matches the strobes.
- Leaving `ST_BOTH_LOW` for any other strobe state is the write transition. It samples the bus into the register and raises a one-cycle update pulse.

A range input decides how the held code is read out. In unipolar range, code zero means 0 V. In bipolar range, the code is offset binary: zero means negative full scale and the mid code means 0 V. Two flags report these cases.

Top module: `dac_strobe_latch`

## Requirements
- R1: A rise of `wr_n` while `cs_n` stays low loads `bus_d` into `code_q`. The new code appears three clock rises after the pin change.
- R2: A rise of `cs_n` while `wr_n` stays low loads `bus_d` into `code_q`, with the same three-clock latency.
- R3: When both strobes rise together from the both-low condition, the register also loads the bus.
- R4: While both strobes are held low, `code_q` does not follow `bus_d`, and no update pulse appears.
- R5: A falling strobe edge does not load the register. Neither does a strobe rising while the other is high, nor both strobes sitting high.
- R6: `load_pulse` is high for exactly one clock cycle, in the cycle in which `code_q` takes the new value, and never otherwise.
- R7: `clr_n` low forces `code_q` to zero immediately, whatever the strobes are doing. A write and a clear in the same cycle resolve to zero.
- R8: After `clr_n` returns high, `code_q` stays zero and `load_pulse` stays low until a full write cycle (both strobes low, then one rising) takes place.
- R9: With `bipolar` = 0, `zero_volts` is 1 exactly when `code_q` is 0x00, and `neg_full_scale` is 0.
- R10: With `bipolar` = 1, `neg_full_scale` is 1 exactly when `code_q` is 0x00, and `zero_volts` is 1 exactly when `code_q` is 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous active-low clear of the code register |
| cs_n | input | 1 | Active-low chip select strobe, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| bus_d | input | 8 | Parallel data bus |
| bipolar | input | 1 | Range mode: 0 unipolar, 1 bipolar offset binary |
| code_q | output | 8 | Held converter code |
| load_pulse | output | 1 | One-cycle pulse marking a register update |
| zero_volts | output | 1 | Held code represents 0 V in the current range |
| neg_full_scale | output | 1 | Held code represents negative full scale (bipolar only) |

## Verification
Each strobe change is driven on a falling clock edge. The result is due after the third rising edge that follows: two for the synchroniser and one for the state and code registers. The checks therefore sample at the falling edge after that third rise, and then sample one cycle later to confirm the pulse has dropped. The range flags are combinational, so they are checked a moment after `bipolar` is changed. The clear is checked right after it is asserted, and after release the bench waits out the two-stage clear synchroniser plus the state register. All sixteen pairs of strobe states are swept against a model that loads only on leaving both-low. Every code value is then loaded and decoded in both ranges.

// File: rtl/dac_reg_pkg.sv
package dac_reg_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR    = 3'd0,
        ST_IDLE     = 3'd1,
        ST_CS_ONLY  = 3'd2,
        ST_WR_ONLY  = 3'd3,
        ST_BOTH_LOW = 3'd4
    } wr_state_e;

    // Map the synchronised strobe pair to the state it represents.
    function automatic wr_state_e strobe_state(input logic cs_n_s, input logic wr_n_s);
        wr_state_e st;
        unique case ({cs_n_s, wr_n_s})
            2'b11:   st = ST_IDLE;
            2'b01:   st = ST_CS_ONLY;
            2'b10:   st = ST_WR_ONLY;
            default: st = ST_BOTH_LOW;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_BIT}};

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) stage_q[gi] <= RST_VEC;
                    else         stage_q[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) stage_q[gi] <= RST_VEC;
                    else         stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/strobe_fsm.sv
module strobe_fsm
    import dac_reg_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic clr_sync_n,
    input  logic cs_n_s,
    input  logic wr_n_s,
    output logic load_now,
    output logic load_pulse
);
    wr_state_e state_q, state_d;

    // Next state and load decision.
    always_comb begin
        state_d  = state_q;
        load_now = 1'b0;
        if (!clr_sync_n) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_CLEAR:    state_d = strobe_state(cs_n_s, wr_n_s);
                ST_IDLE:     state_d = strobe_state(cs_n_s, wr_n_s);
                ST_CS_ONLY:  state_d = strobe_state(cs_n_s, wr_n_s);
                ST_WR_ONLY:  state_d = strobe_state(cs_n_s, wr_n_s);
                ST_BOTH_LOW: begin
                    state_d  = strobe_state(cs_n_s, wr_n_s);
                    load_now = (cs_n_s | wr_n_s);
                end
                default:     state_d = ST_CLEAR;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_CLEAR;
        else         state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) load_pulse <= 1'b0;
        else         load_pulse <= load_now;
    end
endmodule

// File: rtl/code_reg.sv
module code_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              clr_sync_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)          q <= '0;
        else if (!clr_sync_n) q <= '0;
        else if (load)        q <= d;
    end
endmodule

// File: rtl/range_decode.sv
module range_decode #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] code,
    input  logic              bipolar,
    output logic              zero_volts,
    output logic              neg_full_scale
);
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    logic code_is_min;
    assign code_is_min = (code == '0);

    always_comb begin
        if (bipolar) begin
            zero_volts     = (code == MID_CODE);
            neg_full_scale = code_is_min;
        end else begin
            zero_volts     = code_is_min;
            neg_full_scale = 1'b0;
        end
    end
endmodule

// File: rtl/dac_strobe_latch.sv
module dac_strobe_latch #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_d,
    input  logic              bipolar,
    output logic [DATA_W-1:0] code_q,
    output logic              load_pulse,
    output logic              zero_volts,
    output logic              neg_full_scale
);
    logic       clr_sync_n;
    logic [1:0] strobe_s;
    logic       load_now;

    // Clear: asserted at once, released through the chain.
    sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_BIT(1'b0)) u_clr_sync (
        .clk    (clk),
        .arst_n (clr_n),
        .d      (1'b1),
        .q      (clr_sync_n)
    );

    // Strobes: idle high while cleared.
    sync_chain #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_strobe_sync (
        .clk    (clk),
        .arst_n (clr_n),
        .d      ({cs_n, wr_n}),
        .q      (strobe_s)
    );

    strobe_fsm u_fsm (
        .clk        (clk),
        .arst_n     (clr_n),
        .clr_sync_n (clr_sync_n),
        .cs_n_s     (strobe_s[1]),
        .wr_n_s     (strobe_s[0]),
        .load_now   (load_now),
        .load_pulse (load_pulse)
    );

    code_reg #(.DATA_W(DATA_W)) u_code (
        .clk        (clk),
        .arst_n     (clr_n),
        .clr_sync_n (clr_sync_n),
        .load       (load_now),
        .d          (bus_d),
        .q          (code_q)
    );

    range_decode #(.DATA_W(DATA_W)) u_range (
        .code           (code_q),
        .bipolar        (bipolar),
        .zero_volts     (zero_volts),
        .neg_full_scale (neg_full_scale)
    );
endmodule

// File: rtl/dac_reg_checker.sv
module dac_reg_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              clr_n,
    input logic [DATA_W-1:0] bus_d,
    input logic [DATA_W-1:0] code_q,
    input logic              load_pulse
);
    // R7: clear holds the code at zero.
    p_clear_zero_r7: assert property (@(posedge clk)
        !clr_n |-> (code_q == '0));

    // R4 / R6: without a pulse the code does not move.
    p_hold_without_pulse_r4: assert property (@(posedge clk) disable iff (!clr_n)
        !load_pulse |-> $stable(code_q));

    // R6: pulse lasts one cycle.
    p_pulse_one_cycle_r6: assert property (@(posedge clk) disable iff (!clr_n)
        load_pulse |=> !load_pulse);

    // R1 / R2: the loaded code is the bus value at the loading edge.
    p_capture_bus_r1: assert property (@(posedge clk) disable iff (!clr_n)
        load_pulse |-> (code_q == $past(bus_d)));

    // R8: no update right after clear release.
    p_quiet_after_clear_r8: assert property (@(posedge clk)
        !$past(clr_n) |-> !load_pulse);
endmodule

bind dac_strobe_latch dac_reg_checker #(.DATA_W(DATA_W)) u_checker (
    .clk        (clk),
    .clr_n      (clr_n),
    .bus_d      (bus_d),
    .code_q     (code_q),
    .load_pulse (load_pulse)
);

// File: tb/tb_dac_strobe_latch.sv
module tb_dac_strobe_latch;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         wr_n = 1'b1;
    logic [W-1:0] bus_d = '0;
    logic         bipolar = 1'b0;
    logic [W-1:0] code_q;
    logic         load_pulse;
    logic         zero_volts;
    logic         neg_full_scale;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [W-1:0] exp_code = '0;
    logic         prev_cs  = 1'b1;
    logic         prev_wr  = 1'b1;
    int           seq      = 0;

    always #5 clk = ~clk;

    dac_strobe_latch dut (
        .clk            (clk),
        .clr_n          (clr_n),
        .cs_n           (cs_n),
        .wr_n           (wr_n),
        .bus_d          (bus_d),
        .bipolar        (bipolar),
        .code_q         (code_q),
        .load_pulse     (load_pulse),
        .zero_volts     (zero_volts),
        .neg_full_scale (neg_full_scale)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic chk_flags();
        logic zv, nf;
        zv = bipolar ? (code_q == 8'h80) : (code_q == 8'h00);
        nf = bipolar && (code_q == 8'h00);
        chk(zero_volts == zv, bipolar ? "R10 zero_volts" : "R9 zero_volts",
            int'(zero_volts), int'(zv));
        chk(neg_full_scale == nf, bipolar ? "R10 neg_full_scale" : "R9 neg_full_scale",
            int'(neg_full_scale), int'(nf));
    endtask

    task automatic drive(input logic c, input logic w, input logic [W-1:0] d);
        logic  ld;
        string req;
        @(negedge clk);
        cs_n  = c;
        wr_n  = w;
        bus_d = d;
        ld = (!prev_cs && !prev_wr) && (c || w);
        if (ld)              req = (c && w) ? "R3" : (w ? "R1" : "R2");
        else if (!c && !w)   req = "R4";
        else                 req = "R5";
        if (ld) exp_code = d;
        prev_cs = c;
        prev_wr = w;
        repeat (3) @(negedge clk);
        chk(load_pulse == ld, {req, " pulse"}, int'(load_pulse), int'(ld));
        chk(code_q == exp_code, {req, " code"}, int'(code_q), int'(exp_code));
        @(negedge clk);
        chk(load_pulse == 1'b0, "R6 pulse width", int'(load_pulse), 0);
        chk(code_q == exp_code, {req, " code hold"}, int'(code_q), int'(exp_code));
    endtask

    task automatic do_clear(input logic [W-1:0] d);
        @(negedge clk);
        clr_n = 1'b0;
        bus_d = d;
        #1;
        chk(code_q == '0, "R7 clear immediate", int'(code_q), 0);
        exp_code = '0;
        repeat (3) @(negedge clk);
        chk(code_q == '0, "R7 clear held", int'(code_q), 0);
        clr_n = 1'b1;
        prev_cs = cs_n;
        prev_wr = wr_n;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(load_pulse == 1'b0 && code_q == '0, "R8 quiet after clear",
                int'({load_pulse, code_q}), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(code_q == '0, "R7 reset code", int'(code_q), 0);
        chk(load_pulse == 1'b0, "R6 reset pulse", int'(load_pulse), 0);
        chk_flags();
        clr_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(code_q == '0, "R8 zero after release", int'(code_q), 0);

        // Sweep all strobe-state pairs.
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                seq++;
                drive(a[1], a[0], 8'((seq * 53 + 11) & 255));
                seq++;
                drive(b[1], b[0], 8'((seq * 53 + 11) & 255));
            end
        end

        // R4: both low, bus moves, nothing passes.
        drive(1'b1, 1'b1, 8'h3C);
        drive(1'b0, 1'b0, 8'hC3);
        for (int k = 0; k < 4; k++) drive(1'b0, 1'b0, 8'((k * 71 + 5) & 255));
        drive(1'b0, 1'b1, 8'h96);

        // R7: write collides with clear.
        drive(1'b0, 1'b0, 8'h5A);
        @(negedge clk);
        wr_n  = 1'b1;
        prev_wr = 1'b1;
        do_clear(8'hA5);
        drive(1'b1, 1'b1, 8'h11);
        chk(code_q == '0, "R8 no write after clear", int'(code_q), 0);

        // R8: clear released while both low, next rise writes.
        drive(1'b0, 1'b0, 8'h22);
        do_clear(8'h33);
        drive(1'b0, 1'b1, 8'h44);

        // R9 / R10: every code in both ranges.
        for (int v = 0; v < 256; v++) begin
            drive(1'b0, 1'b0, 8'(v ^ 8'hFF));
            drive(1'b1, 1'b0, 8'(v));
            bipolar = 1'b0;
            #1 chk_flags();
            bipolar = 1'b1;
            #1 chk_flags();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule